// File: doc/BRIEF.md
# SDRAM Idle Power-Down Controller

This block sits beside a memory controller's command scheduler and watches for idle periods. Once the controller has been idle for long enough, it asks the external SDRAM to enter a low-power state: clock stop, self refresh or power-down. Which state is chosen depends on a mode-select field, and a separate override asks for deep power-down instead. When traffic shows up while the memory is in a low-power state, the block raises an exit request. It holds that request until the sequencer acknowledges completion, then returns to normal operation and starts counting idle cycles again.

Each low-power mode has its own 4-bit idle-timer code, and the code maps to a threshold on a logarithmic scale. A newly configured code does not act at once. It is copied into the working registers only when a read access is issued, so software makes a new value live with a dummy read. The mode select and the deep override act at once.

Top module: `lpc_top`

## Requirements
- R1: After reset `lowPowerState` is 0 (active), `enterReq` is 0, `exitReq` is 0, and every latched timer code is 0.
- R2: A latched timer code of 0 gives a threshold of 0. Entry is requested at the first clock edge at which the controller is idle, with no request pending and no access issued.
- R3: A latched timer code n in 1..15 gives a threshold T = 2^(n+3). After an activity edge, entry is requested at idle edge T+1 and not before.
- R4: The mode-select encoding is 1 = clock stop, 2 = self refresh and 4 = power-down. On entry, `enterReq` pulses one bit: bit0 for clock stop, bit1 for self refresh, bit2 for power-down and bit3 for deep power-down. On entry `lpKind` becomes 0, 1, 2 or 3 in the same order, and `lowPowerState` becomes 1 (low power).
- R5: A mode-select value other than 1, 2 or 4, with the deep override clear, never produces an entry request.
- R6: With `cfgDeepEn` set, entry requests deep power-down whatever the mode select holds, using a threshold of 0.
- R7: Configured timer codes are copied into the working registers only on a clock edge with `accessIssued` and `accessIsRead` both high. A write access leaves the previous codes in use.
- R8: A pending request, an issued access, or `ctlIdle` low clears the idle count. Counting then restarts from zero.
- R9: In the low-power state, a pending request or an issued access moves the block to exiting (`lowPowerState` = 2) with `exitReq` high. Both stay until an edge with `exitDone` high, which returns the block to active with the idle count cleared.
- R10: Clock stop uses the clock-stop timer code, self refresh uses the self-refresh code, and power-down uses the power-down code.
- R11: `enterReq` is high for exactly one cycle per entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | DRAM-domain clock |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgPdCode | input | 4 | Power-down idle-timer code |
| cfgSrCode | input | 4 | Self-refresh idle-timer code |
| cfgCsCode | input | 4 | Clock-stop idle-timer code |
| cfgMode | input | 3 | Low-power mode select |
| cfgDeepEn | input | 1 | Deep power-down override |
| ctlIdle | input | 1 | Controller has no work in progress |
| reqPending | input | 1 | A memory request is waiting |
| accessIssued | input | 1 | A memory access was issued this cycle |
| accessIsRead | input | 1 | The issued access is a read |
| exitDone | input | 1 | Sequencer finished the low-power exit |
| lowPowerState | output | 2 | 0 active, 1 low power, 2 exiting |
| lpKind | output | 2 | Low-power state in use (0 CS, 1 SR, 2 PD, 3 DPD) |
| enterReq | output | 4 | One-cycle entry request, one bit per state kind |
| exitReq | output | 1 | Exit request, held until exitDone |

## Verification
The assertions check these behaviours on every cycle: entry requests are one-hot, any entry lands in the low-power state, activity and disabled modes block entry, the deep override forces deep power-down once idle, and the exit request persists until it is acknowledged. Some behaviours can only be shown by the bench's scenarios, because they depend on how long the block has been idle or on configuration history. These are the exact idle-edge count at which each threshold fires, the deferral of new timer codes until a read, the choice of the right per-mode code, and the counter restart after an interruption.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
  localparam int N_KIND = 4;

  typedef enum logic [1:0] {ST_ACTIVE = 2'd0, ST_LOWPWR = 2'd1, ST_EXITING = 2'd2} lpState_e;
  typedef enum logic [1:0] {K_CS = 2'd0, K_SR = 2'd1, K_PD = 2'd2, K_DPD = 2'd3} lpKind_e;

  localparam logic [2:0] MODE_CS = 3'd1;
  localparam logic [2:0] MODE_SR = 3'd2;
  localparam logic [2:0] MODE_PD = 3'd4;

  typedef struct packed {
    logic cntClear;
    logic cntRun;
  } cntStrobe_t;
endpackage

// File: rtl/lpc_datapath.sv
module lpc_datapath
  import lpc_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] cfgPdCode,
  input  logic [CODE_W-1:0] cfgSrCode,
  input  logic [CODE_W-1:0] cfgCsCode,
  input  logic [2:0]        cfgMode,
  input  logic              cfgDeepEn,
  input  logic              accessIssued,
  input  logic              accessIsRead,
  input  cntStrobe_t        strobe,
  output logic              thrHit
);
  localparam int CNT_W = (1 << CODE_W) + 3;

  logic [CODE_W-1:0] pdCodeQ, srCodeQ, csCodeQ, selCode;
  logic [CNT_W-1:0]  idleCnt, thr;

  function automatic logic [CNT_W-1:0] codeToThr(input logic [CODE_W-1:0] code);
    logic [CNT_W-1:0] one;
    one = CNT_W'(1);
    return (code == '0) ? '0 : (one << (int'(code) + 3));
  endfunction

  // codes go live only on a read access
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pdCodeQ <= '0;
      srCodeQ <= '0;
      csCodeQ <= '0;
    end else if (accessIssued && accessIsRead) begin
      pdCodeQ <= cfgPdCode;
      srCodeQ <= cfgSrCode;
      csCodeQ <= cfgCsCode;
    end
  end

  always_comb begin
    selCode = '0;
    if (!cfgDeepEn) begin
      case (cfgMode)
        MODE_CS: selCode = csCodeQ;
        MODE_SR: selCode = srCodeQ;
        MODE_PD: selCode = pdCodeQ;
        default: selCode = '0;
      endcase
    end
  end

  assign thr    = codeToThr(selCode);
  assign thrHit = (idleCnt >= thr);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
    end else if (strobe.cntClear) begin
      idleCnt <= '0;
    end else if (strobe.cntRun && (idleCnt < thr)) begin
      idleCnt <= idleCnt + CNT_W'(1);
    end
  end
endmodule

// File: rtl/lpc_control.sv
module lpc_control
  import lpc_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        cfgMode,
  input  logic              cfgDeepEn,
  input  logic              ctlIdle,
  input  logic              reqPending,
  input  logic              accessIssued,
  input  logic              exitDone,
  input  logic              thrHit,
  output cntStrobe_t        strobe,
  output lpState_e          state,
  output lpKind_e           kind,
  output logic [N_KIND-1:0] enterReq
);
  logic     busy, modeOk, goLow;
  lpKind_e  nextKind;

  assign busy   = !ctlIdle || reqPending || accessIssued;
  assign modeOk = (cfgMode == MODE_CS) || (cfgMode == MODE_SR) || (cfgMode == MODE_PD);

  always_comb begin
    if (cfgDeepEn)                 nextKind = K_DPD;
    else if (cfgMode == MODE_CS)   nextKind = K_CS;
    else if (cfgMode == MODE_SR)   nextKind = K_SR;
    else                           nextKind = K_PD;
  end

  assign goLow = (state == ST_ACTIVE) && !busy && (cfgDeepEn || modeOk) && thrHit;

  assign strobe.cntClear = (state != ST_ACTIVE) || busy;
  assign strobe.cntRun   = !strobe.cntClear;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_ACTIVE;
      kind     <= K_CS;
      enterReq <= '0;
    end else begin
      enterReq <= '0;
      case (state)
        ST_ACTIVE: if (goLow) begin
          state    <= ST_LOWPWR;
          kind     <= nextKind;
          enterReq <= N_KIND'(1) << nextKind;
        end
        ST_LOWPWR: if (reqPending || accessIssued) state <= ST_EXITING;
        ST_EXITING: if (exitDone) state <= ST_ACTIVE;
        default: state <= ST_ACTIVE;
      endcase
    end
  end
endmodule

// File: rtl/lpc_top.sv
module lpc_top
  import lpc_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [CODE_W-1:0] cfgPdCode,
  input  logic [CODE_W-1:0] cfgSrCode,
  input  logic [CODE_W-1:0] cfgCsCode,
  input  logic [2:0]        cfgMode,
  input  logic              cfgDeepEn,
  input  logic              ctlIdle,
  input  logic              reqPending,
  input  logic              accessIssued,
  input  logic              accessIsRead,
  input  logic              exitDone,
  output logic [1:0]        lowPowerState,
  output logic [1:0]        lpKind,
  output logic [3:0]        enterReq,
  output logic              exitReq
);
  cntStrobe_t strobe;
  logic       thrHit;
  lpState_e   state;
  lpKind_e    kind;

  lpc_datapath #(.CODE_W(CODE_W)) uDp (
    .clk(clk), .rstN(rstN),
    .cfgPdCode(cfgPdCode), .cfgSrCode(cfgSrCode), .cfgCsCode(cfgCsCode),
    .cfgMode(cfgMode), .cfgDeepEn(cfgDeepEn),
    .accessIssued(accessIssued), .accessIsRead(accessIsRead),
    .strobe(strobe), .thrHit(thrHit)
  );

  lpc_control uCtl (
    .clk(clk), .rstN(rstN),
    .cfgMode(cfgMode), .cfgDeepEn(cfgDeepEn),
    .ctlIdle(ctlIdle), .reqPending(reqPending), .accessIssued(accessIssued),
    .exitDone(exitDone), .thrHit(thrHit),
    .strobe(strobe), .state(state), .kind(kind), .enterReq(enterReq)
  );

  assign lowPowerState = state;
  assign lpKind        = kind;
  assign exitReq       = (state == ST_EXITING);
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker (
  input logic       clk,
  input logic       rstN,
  input logic [2:0] cfgMode,
  input logic       cfgDeepEn,
  input logic       ctlIdle,
  input logic       reqPending,
  input logic       accessIssued,
  input logic       exitDone,
  input logic [1:0] lowPowerState,
  input logic [3:0] enterReq,
  input logic       exitReq
);
  logic modeOk;
  assign modeOk = (cfgMode == 3'd1) || (cfgMode == 3'd2) || (cfgMode == 3'd4);

  // R4 / R11: one entry kind at a time
  a_r4_enter_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(enterReq));

  // R4: an entry pulse coincides with the low-power state
  a_r4_enter_lands_low: assert property (@(posedge clk) disable iff (!rstN)
    (enterReq != 4'd0) |-> (lowPowerState == 2'd1));

  // R11: pulse lasts one cycle
  a_r11_enter_pulse: assert property (@(posedge clk) disable iff (!rstN)
    (enterReq != 4'd0) |=> (enterReq == 4'd0));

  // R5: disabled mode never enters
  a_r5_disabled_no_entry: assert property (@(posedge clk) disable iff (!rstN)
    (lowPowerState == 2'd0 && !modeOk && !cfgDeepEn) |=> (enterReq == 4'd0));

  // R8: activity blocks entry
  a_r8_busy_no_entry: assert property (@(posedge clk) disable iff (!rstN)
    (lowPowerState == 2'd0 && (reqPending || accessIssued || !ctlIdle)) |=> (enterReq == 4'd0));

  // R6: deep override enters deep power-down immediately
  a_r6_deep_immediate: assert property (@(posedge clk) disable iff (!rstN)
    (lowPowerState == 2'd0 && cfgDeepEn && ctlIdle && !reqPending && !accessIssued)
      |=> (enterReq == 4'b1000));

  // R9: traffic in low power triggers exit
  a_r9_exit_on_traffic: assert property (@(posedge clk) disable iff (!rstN)
    (lowPowerState == 2'd1 && (reqPending || accessIssued)) |=> (exitReq && lowPowerState == 2'd2));

  // R9: exit request holds until acknowledged
  a_r9_exit_held: assert property (@(posedge clk) disable iff (!rstN)
    (exitReq && !exitDone) |=> exitReq);

  // R9: acknowledge returns to active
  a_r9_exit_done: assert property (@(posedge clk) disable iff (!rstN)
    (exitReq && exitDone) |=> (lowPowerState == 2'd0 && !exitReq));
endmodule

bind lpc_top lpc_checker uChk (
  .clk(clk), .rstN(rstN), .cfgMode(cfgMode), .cfgDeepEn(cfgDeepEn),
  .ctlIdle(ctlIdle), .reqPending(reqPending), .accessIssued(accessIssued),
  .exitDone(exitDone), .lowPowerState(lowPowerState), .enterReq(enterReq),
  .exitReq(exitReq)
);

// File: tb/tb_lpc_top.sv
module tb_lpc_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [3:0] cfgPdCode = '0, cfgSrCode = '0, cfgCsCode = '0;
  logic [2:0] cfgMode = '0;
  logic       cfgDeepEn = 1'b0;
  logic       ctlIdle = 1'b0, reqPending = 1'b0, accessIssued = 1'b0, accessIsRead = 1'b0;
  logic       exitDone = 1'b0;
  logic [1:0] lowPowerState, lpKind;
  logic [3:0] enterReq;
  logic       exitReq;

  int nChecks = 0;
  int nFails  = 0;

  always #2 clk = ~clk;  // 250 MHz

  lpc_top dut (
    .clk(clk), .rstN(rstN), .cfgPdCode(cfgPdCode), .cfgSrCode(cfgSrCode),
    .cfgCsCode(cfgCsCode), .cfgMode(cfgMode), .cfgDeepEn(cfgDeepEn),
    .ctlIdle(ctlIdle), .reqPending(reqPending), .accessIssued(accessIssued),
    .accessIsRead(accessIsRead), .exitDone(exitDone),
    .lowPowerState(lowPowerState), .lpKind(lpKind), .enterReq(enterReq), .exitReq(exitReq)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // advance n edges, land at a falling edge
  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // one-cycle access; deasserts idle so the counter clears
  task automatic access(input logic isRead);
    ctlIdle = 1'b0; accessIssued = 1'b1; accessIsRead = isRead;
    step(1);
    accessIssued = 1'b0; accessIsRead = 1'b0;
  endtask

  // go idle, expect entry exactly at edge thr+1
  task automatic expectEntry(input string req, input int thr, input int bitIdx, input int kindCode);
    ctlIdle = 1'b1;
    if (thr > 0) begin
      step(thr);
      check(req, lowPowerState, 0);
    end
    step(1);
    check(req, lowPowerState, 1);
    check(req, enterReq, 1 << bitIdx);
    check(req, lpKind, kindCode);
    step(1);
    check("R11", enterReq, 0);
  endtask

  task automatic doExit();
    ctlIdle = 1'b0; reqPending = 1'b1;
    step(1);
    reqPending = 1'b0;
    check("R9", lowPowerState, 2);
    check("R9", exitReq, 1);
    step(3);
    check("R9", exitReq, 1);
    exitDone = 1'b1;
    step(1);
    exitDone = 1'b0;
    check("R9", lowPowerState, 0);
    check("R9", exitReq, 0);
  endtask

  task automatic t_reset();
    check("R1", lowPowerState, 0);
    check("R1", enterReq, 0);
    check("R1", exitReq, 0);
    ctlIdle = 1'b1;
    step(40);
    check("R1", lowPowerState, 0);  // mode 0 at reset
  endtask

  task automatic t_disabled();
    cfgMode = 3'd3; ctlIdle = 1'b1;
    step(40);
    check("R5", lowPowerState, 0);
    cfgMode = 3'd7;
    step(40);
    check("R5", lowPowerState, 0);
  endtask

  task automatic t_immediate();
    access(1'b0);
    cfgMode = 3'd4;
    expectEntry("R2", 0, 2, 2);
    doExit();
  endtask

  task automatic t_pdCode();
    cfgPdCode = 4'd1;
    access(1'b1);
    expectEntry("R3", 16, 2, 2);
    doExit();
  endtask

  task automatic t_deferred();
    cfgPdCode = 4'd2;
    access(1'b0);  // write: keep code 1
    expectEntry("R7", 16, 2, 2);
    doExit();
    access(1'b1);  // read: code 2 live
    expectEntry("R7", 32, 2, 2);
    doExit();
  endtask

  task automatic t_perMode();
    cfgCsCode = 4'd1; cfgSrCode = 4'd2; cfgPdCode = 4'd0;
    access(1'b1);
    cfgMode = 3'd1;
    expectEntry("R10", 16, 0, 0);
    doExit();
    cfgMode = 3'd2;
    expectEntry("R10", 32, 1, 1);
    doExit();
    cfgMode = 3'd4;
    expectEntry("R4", 0, 2, 2);
    doExit();
  endtask

  task automatic t_restart();
    cfgMode = 3'd2;
    ctlIdle = 1'b1;
    step(20);
    reqPending = 1'b1;
    step(1);
    reqPending = 1'b0;
    check("R8", lowPowerState, 0);
    expectEntry("R8", 32, 1, 1);
    doExit();
  endtask

  task automatic t_deep();
    cfgMode = 3'd0; cfgDeepEn = 1'b1;
    expectEntry("R6", 0, 3, 3);
    doExit();
    cfgMode = 3'd2;
    expectEntry("R6", 0, 3, 3);
    doExit();
    cfgDeepEn = 1'b0;
  endtask

  initial begin
    fork
      begin
        step(3);
        rstN = 1'b1;
        step(1);
        t_reset();
        t_disabled();
        t_immediate();
        t_pdCode();
        t_deferred();
        t_perMode();
        t_restart();
        t_deep();
      end
      begin
        step(20000);
        nChecks++;
        nFails++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    disable fork;
    $display("  [TB] %0d tests run, %0d failed", nChecks, nFails);
    $finish;
  end
endmodule